// File: doc/BRIEF.md
# Serial PCM Sample Port with Bit-Clock Loss Detection

This block is the digital edge of a single-channel voice CODEC. It takes 8-bit companded receive samples from a serial input line and hands each finished byte to the core as a parallel word with a one-cycle strobe. It also takes 8-bit transmit samples from the core and shifts them onto a serial output line that is driven only inside its 8-bit slot. Each direction has its own short frame sync. Both directions are timed by an external bit clock whose rate is not configured.

All serial inputs are brought into a free-running system clock domain through synchronisers. Every action is then taken on detected bit-clock edges. Because of this, any bit rate works as long as the system clock is much faster than the bit clock. The same system clock times a watchdog on the bit clock. If that clock stays at one level for too long, the port enters a power-saving state. A dedicated power-down input forces the same state. While power saving is active, both serial paths are stopped and the transmit holding register falls back to the idle code of the selected companding law.

Top module: `pcm_serial_port`

## Requirements
- R1: Receive bits are sampled on falling bit-clock edges, most significant bit first. After the eighth falling edge of a frame, the byte appears on `rx_data` together with a `rx_valid` pulse that lasts exactly one system-clock cycle.
- R2: A rising edge on `rsync` marks the start of a receive word. If it arrives before eight bits have been shifted, the partial word is discarded and counting restarts from the most significant bit.
- R3: Falling bit-clock edges that are not preceded by a new `rsync` rising edge shift nothing. They produce no `rx_valid`, and `rx_data` holds its value.
- R4: After a rising edge on `xsync`, the next rising bit-clock edge starts the transmit slot. Eight bits are driven most significant bit first, one per rising edge. `pcm_oe` is high only during those eight bit times. Outside the slot `pcm_dout` is high impedance.
- R5: A `tx_valid` strobe loads `tx_data` into the transmit holding register. The register is copied into the shifter at the start of each slot, so one loaded byte repeats in every following frame.
- R6: After reset, and until a byte is loaded, the transmitted code is the idle code. The idle code is 0xFF when `alaw_sel` is 0 (µ-law) and 0xD5 when `alaw_sel` is 1 (A-law).
- R7: If the synchronised bit clock shows no edge for `LOSS_CYCLES` system-clock cycles (512 by default), `power_save` rises. This applies whether the clock is stuck high or stuck low. The first new edge clears it.
- R8: `pdn` high forces `power_save` high in the same cycle, whatever the bit clock is doing.
- R9: During power saving:
  - `pcm_oe` is low and a receive word in progress is abandoned without `rx_valid`.
  - The transmit holding register returns to the idle code, and `tx_valid` strobes are ignored.
- R10: The port needs no rate setting. It behaves the same at different bit-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| rsync | input | 1 | Receive short frame sync |
| xsync | input | 1 | Transmit short frame sync |
| pcm_din | input | 1 | Serial receive data |
| alaw_sel | input | 1 | Companding law select: 0 µ-law, 1 A-law |
| pdn | input | 1 | Power-down request |
| tx_data | input | 8 | Transmit sample to load |
| tx_valid | input | 1 | Load strobe for `tx_data` |
| pcm_dout | output | 1 | Serial transmit data, high impedance outside the slot |
| pcm_oe | output | 1 | High while `pcm_dout` is driven |
| rx_data | output | 8 | Last complete receive sample |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |
| power_save | output | 1 | Power-saving state indicator |

## Verification
A wrong receive count or a missed restart appears as a wrong byte or a missing or extra `rx_valid` pulse. This shows up three system cycles after the eighth synchronised falling edge. A wrong transmit shifter or holding register is visible on `pcm_dout` within one bit period of the slot start, and a slot that runs too long or too short appears as `pcm_oe` lasting something other than eight bit times. A fault in the loss counter moves the rise of `power_save` away from the exact cycle the bench model predicts. A fault in the clearing logic shows as a non-idle code in the first slot after power saving.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int SAMPLE_W = 8;

  localparam logic [SAMPLE_W-1:0] MU_IDLE_CODE = 8'hFF;
  localparam logic [SAMPLE_W-1:0] A_IDLE_CODE  = 8'hD5;

  typedef enum logic [0:0] {
    RX_WAIT  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_ARMED = 2'd1,
    TX_SLOT  = 2'd2
  } tx_state_e;

  // idle code for the selected companding law
  function automatic logic [SAMPLE_W-1:0] idle_code(input logic alaw);
    return alaw ? A_IDLE_CODE : MU_IDLE_CODE;
  endfunction

  // receive shift: new bit enters at the LSB, first bit ends at the MSB
  function automatic logic [SAMPLE_W-1:0] shift_in(input logic [SAMPLE_W-1:0] cur,
                                                   input logic bit_in);
    return {cur[SAMPLE_W-2:0], bit_in};
  endfunction

  // transmit shift: MSB leaves first
  function automatic logic [SAMPLE_W-1:0] shift_out(input logic [SAMPLE_W-1:0] cur);
    return {cur[SAMPLE_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/pcm_clk_watch.sv
module pcm_clk_watch #(
  parameter int LOSS_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic lost
);

  localparam int CW = $clog2(LOSS_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES - 1);

  logic [CW-1:0] quiet_cnt;
  logic          limit_hit;

  assign limit_hit = (quiet_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      lost      <= 1'b0;
    end else if (edge_seen) begin
      quiet_cnt <= '0;
      lost      <= 1'b0;
    end else if (limit_hit) begin
      lost      <= 1'b1;
    end else begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_off,
  input  logic                frame_start,
  input  logic                sample_edge,
  input  logic                din,
  output logic [SAMPLE_W-1:0] word,
  output logic                word_vld
);

  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  rx_state_e           st;
  logic [CNT_W-1:0]    bit_cnt;
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] sh_next;
  logic                last_bit;

  assign sh_next  = shift_in(sh, din);
  assign last_bit = (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_WAIT;
      bit_cnt  <= '0;
      sh       <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (hold_off) begin
        st      <= RX_WAIT;
        bit_cnt <= '0;
      end else if (frame_start) begin
        st      <= RX_SHIFT;
        bit_cnt <= '0;
      end else if (sample_edge && st == RX_SHIFT) begin
        sh <= sh_next;
        if (last_bit) begin
          word     <= sh_next;
          word_vld <= 1'b1;
          st       <= RX_WAIT;
          bit_cnt  <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_off,
  input  logic                alaw,
  input  logic                frame_start,
  input  logic                launch_edge,
  input  logic [SAMPLE_W-1:0] load_data,
  input  logic                load_vld,
  output logic                slot_active,
  output logic                slot_start,
  output logic                bit_out
);

  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  tx_state_e           st;
  logic [CNT_W-1:0]    bit_cnt;
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] hold;
  logic                hold_idle;
  logic [SAMPLE_W-1:0] slot_word;

  assign slot_word   = hold_idle ? idle_code(alaw) : hold;
  assign slot_start  = !hold_off && !frame_start && launch_edge && st == TX_ARMED;
  assign slot_active = (st == TX_SLOT);
  assign bit_out     = sh[SAMPLE_W-1];

  // holding register: idle code after reset and during power saving
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_idle <= 1'b1;
    end else if (hold_off) begin
      hold_idle <= 1'b1;
    end else if (load_vld) begin
      hold      <= load_data;
      hold_idle <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_OFF;
      bit_cnt <= '0;
      sh      <= '0;
    end else if (hold_off) begin
      st <= TX_OFF;
    end else if (frame_start) begin
      st <= TX_ARMED;
    end else if (launch_edge) begin
      if (st == TX_ARMED) begin
        st      <= TX_SLOT;
        bit_cnt <= '0;
        sh      <= slot_word;
      end else if (st == TX_SLOT) begin
        if (bit_cnt == LAST) begin
          st <= TX_OFF;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= shift_out(sh);
        end
      end
    end
  end

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int LOSS_CYCLES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                rsync,
  input  logic                xsync,
  input  logic                pcm_din,
  input  logic                alaw_sel,
  input  logic                pdn,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                pcm_dout,
  output logic                pcm_oe,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  output logic                power_save
);

  localparam int N_IN  = 4;
  localparam int N_CTL = 3;

  logic [N_IN-1:0]  pins_q;
  logic [N_CTL-1:0] ctl_prev;
  logic             bclk_rise;
  logic             bclk_fall;
  logic             bclk_edge;
  logic             rsync_rise;
  logic             xsync_rise;
  logic             clk_lost;
  logic             tx_active;
  logic             tx_bit;
  logic             tx_slot_start;

  pcm_in_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pcm_din, xsync, rsync, bclk}),
    .q    (pins_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_prev <= '0;
    else        ctl_prev <= pins_q[N_CTL-1:0];
  end

  assign bclk_rise  =  pins_q[0] & ~ctl_prev[0];
  assign bclk_fall  = ~pins_q[0] &  ctl_prev[0];
  assign bclk_edge  = bclk_rise | bclk_fall;
  assign rsync_rise =  pins_q[1] & ~ctl_prev[1];
  assign xsync_rise =  pins_q[2] & ~ctl_prev[2];

  pcm_clk_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_seen(bclk_edge),
    .lost     (clk_lost)
  );

  assign power_save = clk_lost | pdn;

  pcm_rx_deser u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_off   (power_save),
    .frame_start(rsync_rise),
    .sample_edge(bclk_fall),
    .din        (pins_q[3]),
    .word       (rx_data),
    .word_vld   (rx_valid)
  );

  pcm_tx_ser u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_off   (power_save),
    .alaw       (alaw_sel),
    .frame_start(xsync_rise),
    .launch_edge(bclk_rise),
    .load_data  (tx_data),
    .load_vld   (tx_valid),
    .slot_active(tx_active),
    .slot_start (tx_slot_start),
    .bit_out    (tx_bit)
  );

  assign pcm_oe   = tx_active & ~power_save;
  assign pcm_dout = pcm_oe ? tx_bit : 1'bz;

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       power_save,
  input logic       pcm_oe,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       bclk_edge,
  input logic       bclk_rise,
  input logic       clk_lost,
  input logic       tx_slot_start
);

  // R1: the receive strobe lasts one cycle
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3: received data only changes with a strobe
  p_rx_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  // R4: driving begins only with a slot started on a rising bit-clock edge
  p_oe_from_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_oe) |-> ($past(bclk_rise) && $past(tx_slot_start)));

  // R7: loss is declared only after a cycle with no bit-clock edge
  p_loss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_lost) |-> !$past(bclk_edge));

  // R9: no receive strobe after a power-saving cycle
  p_rx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    power_save |=> !rx_valid);

  // R9: serializer has been stopped when power saving ends
  p_tx_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_save) |-> !pcm_oe);

endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .power_save   (power_save),
  .pcm_oe       (pcm_oe),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .bclk_edge    (bclk_edge),
  .bclk_rise    (bclk_rise),
  .clk_lost     (clk_lost),
  .tx_slot_start(tx_slot_start)
);

// File: tb/pcm_serial_port_tb.sv
`timescale 1ns/1ps
module pcm_serial_port_tb_top;

  localparam int LOSS = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       rsync = 1'b0;
  logic       xsync = 1'b0;
  logic       pcm_din = 1'b0;
  logic       alaw_sel = 1'b0;
  logic       pdn = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  wire        pcm_dout;
  logic       pcm_oe;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       power_save;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_serial_port #(.LOSS_CYCLES(LOSS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .rsync(rsync), .xsync(xsync),
    .pcm_din(pcm_din), .alaw_sel(alaw_sel), .pdn(pdn), .tx_data(tx_data),
    .tx_valid(tx_valid), .pcm_dout(pcm_dout), .pcm_oe(pcm_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .power_save(power_save)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // bit-clock generator, can be parked at a level
  bit bclk_run = 0;
  int bclk_hp = 8;
  int park_lvl = -1;
  int hc = 0;
  always @(negedge clk) begin
    if (bclk_run && !(park_lvl >= 0 && int'(bclk) == park_lvl)) begin
      if (hc >= bclk_hp - 1) begin bclk <= ~bclk; hc <= 0; end
      else hc <= hc + 1;
    end
  end

  // ---------------- behavioural reference model ----------------
  bit hb[4], hr[4], hx[4], hd[4];    // input samples, index = age in cycles
  bit m_lost;
  int m_quiet;
  bit m_rx_on;  int m_rx_n;  int m_rx_acc;  int m_rx_data;  bit m_rx_v;
  int m_tx_mode;                      // 0 off, 1 waiting, 2 sending
  int m_tx_n;   int m_tx_word;  int m_hold;  bit m_hold_idle;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin hb[k] = 0; hr[k] = 0; hx[k] = 0; hd[k] = 0; end
      m_lost = 0; m_quiet = 0; m_rx_on = 0; m_rx_n = 0; m_rx_acc = 0;
      m_rx_data = 0; m_rx_v = 0; m_tx_mode = 0; m_tx_n = 0; m_tx_word = 0;
      m_hold = 0; m_hold_idle = 1;
    end else begin
      bit ps, brise, bfall, rstart, xstart;
      ps     = m_lost || pdn;
      brise  = hb[2] && !hb[3];
      bfall  = !hb[2] && hb[3];
      rstart = hr[2] && !hr[3];
      xstart = hx[2] && !hx[3];
      m_rx_v = 0;
      if (ps) begin m_rx_on = 0; m_rx_n = 0; end
      else if (rstart) begin m_rx_on = 1; m_rx_n = 0; end
      else if (bfall && m_rx_on) begin
        m_rx_acc = ((m_rx_acc * 2) + int'(hd[2])) % 256;
        m_rx_n++;
        if (m_rx_n == 8) begin
          m_rx_data = m_rx_acc; m_rx_v = 1; m_rx_on = 0; m_rx_n = 0;
        end
      end
      if (ps) m_tx_mode = 0;
      else if (xstart) m_tx_mode = 1;
      else if (brise) begin
        if (m_tx_mode == 1) begin
          m_tx_mode = 2; m_tx_n = 0;
          m_tx_word = m_hold_idle ? (alaw_sel ? 'hD5 : 'hFF) : m_hold;
        end else if (m_tx_mode == 2) begin
          if (m_tx_n == 7) m_tx_mode = 0;
          else begin m_tx_n++; m_tx_word = (m_tx_word * 2) % 256; end
        end
      end
      if (ps) m_hold_idle = 1;
      else if (tx_valid) begin m_hold = int'(tx_data); m_hold_idle = 0; end
      if (brise || bfall) begin m_quiet = 0; m_lost = 0; end
      else if (m_quiet == LOSS - 1) m_lost = 1;
      else m_quiet++;
      for (int k = 3; k > 0; k--) begin
        hb[k] = hb[k-1]; hr[k] = hr[k-1]; hx[k] = hx[k-1]; hd[k] = hd[k-1];
      end
      hb[1] = bclk; hr[1] = rsync; hx[1] = xsync; hd[1] = pcm_din;
    end
  end

  // every-cycle comparison against the model
  int vcnt = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_ps, e_oe;
      e_ps = m_lost || pdn;
      e_oe = (m_tx_mode == 2) && !e_ps;
      if (rx_valid === 1'b1) vcnt++;
      check(power_save === e_ps, "R7", "power_save", int'(power_save), int'(e_ps));
      check(rx_valid === m_rx_v, "R1", "rx_valid", int'(rx_valid), int'(m_rx_v));
      check(rx_data === m_rx_data[7:0], "R1", "rx_data", int'(rx_data), m_rx_data);
      check(pcm_oe === e_oe, "R4", "pcm_oe", int'(pcm_oe), int'(e_oe));
      if (e_oe) check(pcm_dout === m_tx_word[7], "R4", "pcm_dout", int'(pcm_dout), m_tx_word / 128);
      else      check(pcm_dout === 1'bz, "R4", "pcm_dout high-z", int'(pcm_dout), 0);
    end
  end

  // capture of transmitted bits at the bit-clock falling edge
  logic [7:0] cap = 8'h00;
  int cap_n = 0;
  always @(negedge bclk) begin
    if (pcm_oe === 1'b1) begin cap = {cap[6:0], pcm_dout}; cap_n++; end
  end

  task automatic frame(input logic [7:0] rb, input bit use_x, input int nb);
    cap_n = 0; cap = 8'h00;
    for (int i = 0; i < nb; i++) begin
      @(posedge bclk);
      if (i == 0) begin rsync = 1'b1; xsync = use_x; end
      else if (i == 1) begin rsync = 1'b0; xsync = 1'b0; end
      pcm_din = rb[7-i];
    end
    if (nb == 8) repeat (3) @(posedge bclk);
    rsync = 1'b0; xsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic full_check(input logic [7:0] rb, input logic [7:0] tb, input string rq);
    vcnt = 0;
    frame(rb, 1'b1, 8);
    check(rx_data === rb, "R1", "received byte", int'(rx_data), int'(rb));
    check(vcnt == 1, "R1", "strobe count", vcnt, 1);
    check(cap_n == 8, "R4", "slot length", cap_n, 8);
    check(cap === tb, rq, "transmitted byte", int'(cap), int'(tb));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rx_valid === 1'b0, "R6", "reset rx_valid", int'(rx_valid), 0);
    check(pcm_oe === 1'b0, "R4", "reset pcm_oe", int'(pcm_oe), 0);
    check(pcm_dout === 1'bz, "R4", "reset pcm_dout", int'(pcm_dout), 0);
    rst_n = 1'b1;
    bclk_run = 1;
    repeat (2) @(negedge clk);
    check(power_save === 1'b0, "R7", "power_save after reset", int'(power_save), 0);

    full_check(8'hA5, 8'hFF, "R6");          // idle code, mu-law
    load_tx(8'h3C);
    full_check(8'h5A, 8'h3C, "R5");
    full_check(8'h81, 8'h3C, "R5");          // holding register persists

    // R2: restart after a partial word
    vcnt = 0;
    frame(8'h00, 1'b0, 4);
    frame(8'hC3, 1'b0, 8);
    check(rx_data === 8'hC3, "R2", "byte after restart", int'(rx_data), 'hC3);
    check(vcnt == 1, "R2", "strobes after restart", vcnt, 1);

    // R3: bit-clock falls without a sync
    vcnt = 0;
    for (int i = 0; i < 12; i++) begin @(posedge bclk); pcm_din = ~pcm_din; end
    repeat (4) @(negedge clk);
    check(vcnt == 0, "R3", "strobes without sync", vcnt, 0);
    check(rx_data === 8'hC3, "R3", "data without sync", int'(rx_data), 'hC3);

    // R10: slower bit clock
    bclk_hp = 20;
    load_tx(8'h69);
    full_check(8'h96, 8'h69, "R10");
    bclk_hp = 8;

    // R7/R9: bit clock parked high
    park_lvl = 1;
    repeat (LOSS + 40) @(negedge clk);
    check(power_save === 1'b1, "R7", "loss with clock high", int'(power_save), 1);
    check(pcm_oe === 1'b0, "R9", "oe in power saving", int'(pcm_oe), 0);
    load_tx(8'h11);                          // ignored while saving power
    park_lvl = -1;
    repeat (bclk_hp + 8) @(negedge clk);
    check(power_save === 1'b0, "R7", "loss cleared", int'(power_save), 0);
    full_check(8'h42, 8'hFF, "R9");

    // R7: bit clock parked low
    park_lvl = 0;
    repeat (LOSS + 40) @(negedge clk);
    check(power_save === 1'b1, "R7", "loss with clock low", int'(power_save), 1);
    park_lvl = -1;
    repeat (bclk_hp + 8) @(negedge clk);

    // R8/R9: power-down in the middle of a word
    load_tx(8'hE7);
    vcnt = 0;
    frame(8'h77, 1'b1, 4);
    pdn = 1'b1;
    @(negedge clk);
    check(power_save === 1'b1, "R8", "pdn forces power_save", int'(power_save), 1);
    repeat (40) @(negedge clk);
    pdn = 1'b0;
    repeat (40) @(negedge clk);
    check(vcnt == 0, "R9", "aborted word strobe", vcnt, 0);
    full_check(8'h18, 8'hFF, "R9");

    // R6: A-law idle code after reset
    alaw_sel = 1'b1;
    do_reset();
    full_check(8'h24, 8'hD5, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule